// File: doc/BRIEF.md
# Configuration Request Packet Generator

This block turns one configuration-space read or write request into the four 32-bit words that a root port's transmit path sends: three header words followed by one data word. A requester presents the target bus, device, function, register offset, access size, direction and write data together with a valid strobe. The block also samples the local root bus number and the secondary bus number at the moment it accepts the request.

At acceptance the generator works out the header. It picks a Type 0 or Type 1 request by comparing the target bus with the secondary bus. It derives the byte enables from the offset and the access size, inserts a fixed tag for each direction and moves sub-word write data into its byte lane. It then streams the words one per cycle on a flagged word output, pausing whenever the downstream ready is low. A done pulse marks the cycle in which the final word is taken.

Top module: `cfg_tlp_gen`

## Requirements
- R1: Word 0 is {kind[7:0], 14'b0, length[9:0]} with length = 1. The kind byte is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write.
- R2: Type 1 is used only when the target bus is strictly greater than the secondary bus; an equal or smaller target bus gives Type 0.
- R3: Word 1 is {root_bus[7:0], ROOT_DEVFN[7:0], tag[7:0], byte_enable[7:0]}, where ROOT_DEVFN defaults to 0x00 and tag is 0x1D for a read and 0x10 for a write.
- R4: Word 2 is {bus[7:0], dev[4:0], fn[2:0], 4'b0, offset[11:2], 2'b00}.
- R5: With size code 0 (byte) the byte enables are 0x01 shifted left by offset[1:0]. With size code 1 (halfword) they are 0x03 shifted left by offset[1:0], giving 0x18 at offset 3. Size codes 2 and 3 (word) give 0x0F.
- R6: For a read, word 3 is zero. For a word write it is the write data unchanged. For a byte or halfword write it is the low 1 or 2 bytes of the write data moved up by 8*offset[1:0] bits, with lanes that fall past bit 31 dropped and every other lane zero.
- R7: The words leave in order 0, 1, 2, 3. The start flag is high only with word 0 and the end flag only with word 3.
- R8: While valid is high and ready is low, the word and both flags hold their values.
- R9: A request is taken at a rising edge where valid and req_ready_o are both high, and word 0 appears in the following cycle. req_ready_o stays low from acceptance until the cycle after the end word is taken, and a request offered in that window has no effect on the packet in flight.
- R10: done_o is high exactly in the cycle in which the end word is transferred (valid, end flag and ready all high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Generator idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_dev_i | input | 5 | Target device number |
| req_fn_i | input | 3 | Target function number |
| req_off_i | input | 12 | Register byte offset |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata_i | input | 32 | Write data, right-aligned for sub-word sizes |
| root_bus_i | input | 8 | Local root bus number |
| sec_bus_i | input | 8 | Secondary bus number |
| tx_data_o | output | 32 | Outgoing word |
| tx_valid_o | output | 1 | Outgoing word valid |
| tx_sop_o | output | 1 | Start-of-packet flag |
| tx_eop_o | output | 1 | End-of-packet flag |
| tx_ready_i | input | 1 | Downstream accepts the word |
| done_o | output | 1 | Final word transferred this cycle |

## Verification
The assertions assume that the request fields, the root bus and the secondary bus are steady in the cycle the request is taken. They also assume that tx_ready_i is a plain level that is sampled together with tx_valid_o. The stimulus changes inputs only on falling edges and leaves the request fields alone while valid is being offered to an idle generator. It sweeps all size codes and all four offset alignments in both directions, with the target bus placed below, equal to and above the secondary bus. It inserts stalls on a rotating subset of words, and on one packet it presents a conflicting request while the generator is busy.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int WORD_W    = 32;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int OFF_W     = 12;
  localparam int BE_W      = 8;
  localparam int TAG_W     = 8;
  localparam int LEN_W     = 10;
  localparam int KIND_W    = 8;
  localparam int NUM_WORDS = 4;
  localparam int LANES     = WORD_W / 8;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  // kind byte: base read Type 0, bit 6 = write, bit 0 = Type 1
  localparam logic [KIND_W-1:0] KIND_BASE  = 8'h04;
  localparam logic [KIND_W-1:0] KIND_WRITE = 8'h40;
  localparam logic [KIND_W-1:0] KIND_TYPE1 = 8'h01;

  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] pkt_t;
endpackage

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_tlp_pkg::*;
(
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        off_lo_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [BE_W-1:0]   be_o,
  output logic [WORD_W-1:0] data_o
);
  acc_size_e size;
  logic      full;
  int        nbytes;

  assign size = acc_size_e'(size_i);
  assign full = (size == SZ_WORD) || (size == SZ_WRD2);

  always_comb begin
    nbytes = (size == SZ_HALF) ? 2 : 1;
    unique case (size)
      SZ_BYTE: be_o = BE_W'(8'h01) << off_lo_i;
      SZ_HALF: be_o = BE_W'(8'h03) << off_lo_i;
      default: be_o = BE_W'(8'h0F);
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int src;
    always_comb begin
      src = k - int'(off_lo_i);
      data_o[8*k +: 8] = 8'h00;
      if (write_i) begin
        if (full) begin
          data_o[8*k +: 8] = wdata_i[8*k +: 8];
        end else if (src >= 0 && src < nbytes) begin
          data_o[8*k +: 8] = wdata_i[8*src +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0]       ROOT_DEVFN = 8'h00,
  parameter logic [TAG_W-1:0] RD_TAG     = 8'h1D,
  parameter logic [TAG_W-1:0] WR_TAG     = 8'h10
) (
  input  logic              write_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  output logic [WORD_W-1:0] hdr0_o,
  output logic [WORD_W-1:0] hdr1_o,
  output logic [WORD_W-1:0] hdr2_o
);
  localparam int PAD0 = WORD_W - KIND_W - LEN_W;
  localparam int PAD2 = WORD_W - BUS_W - DEV_W - FN_W - OFF_W;

  logic              type1;
  logic [KIND_W-1:0] kind;

  assign type1 = bus_i > sec_bus_i;

  always_comb begin
    kind = KIND_BASE;
    if (write_i) kind = kind | KIND_WRITE;
    if (type1)   kind = kind | KIND_TYPE1;
  end

  assign hdr0_o = {kind, {PAD0{1'b0}}, LEN_W'(1)};
  assign hdr1_o = {root_bus_i, ROOT_DEVFN, (write_i ? WR_TAG : RD_TAG), be_i};
  assign hdr2_o = {bus_i, dev_i, fn_i, {PAD2{1'b0}}, off_i[OFF_W-1:2], 2'b00};
endmodule

// File: rtl/cfg_tx_seq.sv
module cfg_tx_seq
  import cfg_tlp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  pkt_t              words_i,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  pkt_t             words_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        words_q <= words_i;
        idx_q   <= '0;
        busy_q  <= 1'b1;
      end
    end else if (tx_ready_i) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = busy_q ? words_q[idx_q] : '0;
  assign tx_sop_o   = busy_q && (idx_q == '0);
  assign tx_eop_o   = busy_q && (idx_q == LAST);
  assign done_o     = tx_eop_o && tx_ready_i;
endmodule

// File: rtl/cfg_tlp_gen.sv
module cfg_tlp_gen
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] ROOT_DEVFN = 8'h00,
  parameter logic [7:0] RD_TAG     = 8'h1D,
  parameter logic [7:0] WR_TAG     = 8'h10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_bus_i,
  input  logic [4:0]  req_dev_i,
  input  logic [2:0]  req_fn_i,
  input  logic [11:0] req_off_i,
  input  logic [1:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  input  logic [7:0]  root_bus_i,
  input  logic [7:0]  sec_bus_i,
  output logic [31:0] tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_sop_o,
  output logic        tx_eop_o,
  input  logic        tx_ready_i,
  output logic        done_o
);
  logic [BE_W-1:0]   be;
  logic [WORD_W-1:0] data_w;
  logic [WORD_W-1:0] hdr0, hdr1, hdr2;
  pkt_t              pkt;
  logic              busy;
  logic              accept;

  cfg_lane_map i_lane (
    .write_i  (req_write_i),
    .size_i   (req_size_i),
    .off_lo_i (req_off_i[1:0]),
    .wdata_i  (req_wdata_i),
    .be_o     (be),
    .data_o   (data_w)
  );

  cfg_hdr_build #(
    .ROOT_DEVFN (ROOT_DEVFN),
    .RD_TAG     (RD_TAG),
    .WR_TAG     (WR_TAG)
  ) i_hdr (
    .write_i    (req_write_i),
    .bus_i      (req_bus_i),
    .dev_i      (req_dev_i),
    .fn_i       (req_fn_i),
    .off_i      (req_off_i),
    .be_i       (be),
    .root_bus_i (root_bus_i),
    .sec_bus_i  (sec_bus_i),
    .hdr0_o     (hdr0),
    .hdr1_o     (hdr1),
    .hdr2_o     (hdr2)
  );

  assign pkt    = {data_w, hdr2, hdr1, hdr0};
  assign accept = req_valid_i && req_ready_o;

  cfg_tx_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .words_i    (pkt),
    .tx_ready_i (tx_ready_i),
    .busy_o     (busy),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_sop_o   (tx_sop_o),
    .tx_eop_o   (tx_eop_o),
    .done_o     (done_o)
  );

  assign req_ready_o = !busy;
endmodule

// File: rtl/cfg_tlp_gen_chk.sv
module cfg_tlp_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_write_i,
  input logic [7:0]  req_bus_i,
  input logic [7:0]  sec_bus_i,
  input logic [31:0] tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_sop_o,
  input logic        tx_eop_o,
  input logic        tx_ready_i,
  input logic        done_o
);
  logic type1_q, write_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type1_q <= 1'b0;
      write_q <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      type1_q <= req_bus_i > sec_bus_i;
      write_q <= req_write_i;
    end
  end

  AST_KIND_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_sop_o |-> tx_data_o[30] == write_q && tx_data_o[9:0] == 10'd1); // R1
  AST_KIND_TYPE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_sop_o |-> tx_data_o[24] == type1_q); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_sop_o, tx_eop_o})); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o)); // R8
  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> tx_valid_o && tx_sop_o); // R9
  AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !req_ready_o); // R9
  AST_EOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_eop_o && tx_ready_i |=> !tx_valid_o && req_ready_o); // R9
  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_valid_o && tx_eop_o && tx_ready_i); // R10
  AST_DONE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_eop_o && tx_ready_i |-> done_o); // R10
endmodule

bind cfg_tlp_gen cfg_tlp_gen_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_bus_i   (req_bus_i),
  .sec_bus_i   (sec_bus_i),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_sop_o    (tx_sop_o),
  .tx_eop_o    (tx_eop_o),
  .tx_ready_i  (tx_ready_i),
  .done_o      (done_o)
);

// File: tb/test_cfg_tlp_gen.sv
`timescale 1ns/1ps
module test_cfg_tlp_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_bus_i = '0;
  logic [4:0]  req_dev_i = '0;
  logic [2:0]  req_fn_i = '0;
  logic [11:0] req_off_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [7:0]  root_bus_i = '0;
  logic [7:0]  sec_bus_i = '0;
  logic [31:0] tx_data_o;
  logic        tx_valid_o, tx_sop_o, tx_eop_o, done_o;
  logic        tx_ready_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_tlp_gen i_cfg_tlp_gen (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int w, bit wr, logic [7:0] bus, logic [7:0] sec,
      logic [7:0] root, logic [4:0] dev, logic [2:0] fn, logic [11:0] off, logic [1:0] sz,
      logic [31:0] wd);
    logic [7:0]  kind, be;
    logic [63:0] wide;
    int          o;
    o    = int'(off[1:0]);
    kind = 8'h04 + (wr ? 8'h40 : 8'h00) + ((bus > sec) ? 8'h01 : 8'h00);
    be   = (sz == 2'd0) ? 8'(1 << o) : (sz == 2'd1) ? 8'(3 << o) : 8'h0F;
    case (w)
      0: return {kind, 14'd0, 10'd1};
      1: return {root, 8'h00, (wr ? 8'h10 : 8'h1D), be};
      2: return {bus, dev, fn, 4'd0, off[11:2], 2'b00};
      default: begin
        if (!wr) return 32'd0;
        if (sz >= 2'd2) return wd;
        wide = (sz == 2'd0) ? 64'(wd & 32'hFF) : 64'(wd & 32'hFFFF);
        wide = wide * (64'd1 << (8 * o));
        return wide[31:0];
      end
    endcase
  endfunction

  task automatic run_pkt(input bit wr, input logic [7:0] bus, input logic [7:0] sec,
      input logic [7:0] root, input logic [4:0] dev, input logic [2:0] fn,
      input logic [11:0] off, input logic [1:0] sz, input logic [31:0] wd,
      input logic [3:0] stall, input bit intrude);
    logic [31:0] e;
    @(negedge clk_i);
    req_write_i = wr; req_bus_i = bus; sec_bus_i = sec; root_bus_i = root;
    req_dev_i = dev; req_fn_i = fn; req_off_i = off; req_size_i = sz; req_wdata_i = wd;
    req_valid_i = 1'b1; tx_ready_i = 1'b0;
    #1 chk(req_ready_o == 1'b1, "R9 idle ready", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    if (intrude) begin
      // R9: conflicting request offered while busy must be ignored
      req_write_i = ~wr; req_bus_i = bus + 8'd7; req_dev_i = ~dev; req_fn_i = ~fn;
      req_off_i = ~off; req_size_i = ~sz; req_wdata_i = ~wd; sec_bus_i = ~sec; root_bus_i = ~root;
    end else begin
      req_valid_i = 1'b0;
    end
    for (int w = 0; w < 4; w++) begin
      e = exp_word(w, wr, bus, sec, root, dev, fn, off, sz, wd);
      if (stall[w]) begin
        tx_ready_i = 1'b0;
        #1;
        chk(tx_valid_o && !done_o, "R10 no done on stall", 32'(done_o), 32'd0);
        @(negedge clk_i);
        #1 chk(tx_valid_o && tx_data_o == e, "R8 hold on stall", tx_data_o, e);
      end
      tx_ready_i = 1'b1;
      #1;
      chk(tx_valid_o == 1'b1, "R9 valid in packet", 32'(tx_valid_o), 32'd1);
      chk(tx_data_o == e, (w == 0) ? "R1 R2 word0" : (w == 1) ? "R3 R5 word1" :
          (w == 2) ? "R4 word2" : "R6 data word", tx_data_o, e);
      chk(tx_sop_o == (w == 0) && tx_eop_o == (w == 3), "R7 flags",
          {30'd0, tx_sop_o, tx_eop_o}, {30'd0, w == 0, w == 3});
      chk(done_o == (w == 3), "R10 done", 32'(done_o), 32'(w == 3));
      chk(req_ready_o == 1'b0, "R9 busy", 32'(req_ready_o), 32'd0);
      @(negedge clk_i);
      if (w == 3) req_valid_i = 1'b0;
    end
    tx_ready_i = 1'b0;
    #1 chk(!tx_valid_o && req_ready_o, "R9 release", {30'd0, tx_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%08h exp=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk_i);
    #1 chk(!tx_valid_o && !done_o && !req_ready_o == 1'b0, "R9 reset idle",
           {30'd0, tx_valid_o, req_ready_o}, 32'd1);
    rst_ni = 1'b1;
    for (int rel = 0; rel < 3; rel++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int o = 0; o < 4; o++) begin
          for (int wr = 0; wr < 2; wr++) begin
            logic [7:0] sec;
            sec = (rel == 1) ? 8'hFE : 8'h20 + 8'(sz);
            // R2: target below, equal to, above secondary bus
            run_pkt(wr[0], (rel == 0) ? sec - 8'd1 : (rel == 1) ? sec : sec + 8'd1, sec,
                    8'(n * 3), 5'(n), 3'(n * 5), 12'(n * 52 + o), sz[1:0],
                    32'hA1B2C3D4 ^ 32'(n * 32'h01010101), 4'(n), 1'b0);
            n++;
          end
        end
      end
    end
    // R9: busy window ignores a second request
    run_pkt(1'b1, 8'h05, 8'h04, 8'h02, 5'h1F, 3'h7, 12'hFFF, 2'd1, 32'h0000BEEF, 4'b1010, 1'b1);
    run_pkt(1'b0, 8'h00, 8'h00, 8'hFF, 5'h00, 3'h0, 12'h000, 2'd2, 32'hFFFFFFFF, 4'b0000, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule